// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

This block is a down-counting timer that can serve as a periodic tick source, as a software-liveness watchdog that asks the system to reset, or as both at once. Its counting side runs from one of two source clocks, picked by a static select pin. It advances only on prescaler ticks, which come every 2^(PS+1) cycles of the chosen clock, so the division ranges from /2 up to /65536. Software reaches the block through a small register port in the fast bus clock domain. Each accepted write is handed to the counting domain with a toggle handshake and takes effect on the next prescaler tick. While that hand-off is in flight, a busy bit reads back as 1.

In combined mode the timer first gives software a warning interrupt. If software does not restart the count before the next expiry, the timer requests a reset. Software restarts the count by writing a 16-bit key. The interrupt output is the sticky expiry flag, brought into the bus domain. The reset request is a single-cycle pulse in the selected source clock domain.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset, every register reads 0 (CONTROL at address 0, RELOAD at 1, COUNT at 2), `irq` is 0, `soft_rst_req` is 0 and the busy bit (CONTROL bit 31) is 0.
- R2: The counter steps once per prescaler tick. A tick comes every 2^(PS+1) cycles of `clk_a` when `clk_sel` is 0 and of `clk_b` when `clk_sel` is 1. PS sits in CONTROL bits 7:4.
- R3: An accepted write to CONTROL, RELOAD or a valid restart sets the busy bit from the next bus cycle until the write is applied at a tick. A write made while busy is 1 is discarded.
- R4: Writing 0xA5C3 into bits 15:0 of the RESTART register (address 3) loads COUNT from RELOAD and clears the combined-mode warning state. Any other value is ignored: it leaves busy at 0 and COUNT unchanged.
- R5: With interval enable (CONTROL bit 0) set, the step that takes COUNT from 1 to 0 sets the sticky flag, which reads at CONTROL bit 2 and drives `irq`. Writing 1 to bit 2 clears the flag.
- R6: With reset enable (CONTROL bit 1) set alone, every step from 1 to 0 gives a one-cycle `soft_rst_req` pulse. Pulses are spaced (RELOAD+1)·2^(PS+1) source cycles apart, because the step after 0 reloads RELOAD.
- R7: With both enables set, the first expiry only sets the flag. The next expiry with no restart in between pulses `soft_rst_req`. A restart in between puts off the reset by one more expiry.
- R8: COUNT reads back the current count. With both enables clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| clk_a | input | 1 | Source clock 0 |
| clk_b | input | 1 | Source clock 1 |
| clk_sel | input | 1 | Source select, static while counting |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Sticky expiry flag, bus domain |
| soft_rst_req | output | 1 | One-cycle reset request, source domain |

## Verification
A stuck or wrong prescaler or source select shows up at once as a wrong spacing between reset pulses, which is measured in source cycles. A warning state that is not cleared gives a reset pulse one reload period early. A scoreboard that expects one warning and then one reset catches that, as well as pulses that come in the wrong order or too often. A lost handshake leaves busy stuck at 1 within a few source cycles. A wrongly accepted key moves COUNT or raises busy on the very next bus read.

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer #(
  parameter int CNT_W = 24,
  parameter int PS_W = 4,
  parameter logic [15:0] KEY = 16'hA5C3
) (
  input  logic        bus_clk,
  input  logic        rst_n,
  input  logic        clk_a,
  input  logic        clk_b,
  input  logic        clk_sel,
  input  logic        bus_wr_en,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        soft_rst_req
);
  localparam int DIV_W = 1 << PS_W;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOAD = 2'd1, A_COUNT = 2'd2, A_KEY = 2'd3;

  logic src_clk;
  assign src_clk = clk_sel ? clk_b : clk_a;

  // bus domain
  logic             sh_int_en, sh_rst_en;
  logic [PS_W-1:0]  sh_ps;
  logic [CNT_W-1:0] sh_load;
  logic             req_tgl, ack_b1, ack_b2, busy, wr_ok;
  logic [1:0]       cmd_kind;
  logic [CNT_W-1:0] cmd_data;
  logic             flag_b1, flag_b2;
  logic [CNT_W-1:0] cnt_b1, cnt_b2, cnt_vis;
  logic             unused_wdata;

  // source domain
  logic             req_s1, req_s2, ack_tgl;
  logic [DIV_W-1:0] presc, div_mask;
  logic             run_int, run_rst, flag, armed;
  logic [PS_W-1:0]  ps;
  logic [CNT_W-1:0] load, cnt;
  logic             tick, pend, apply, step;

  assign unused_wdata = ^bus_wdata[31:CNT_W];
  assign busy  = req_tgl ^ ack_b2;
  assign wr_ok = bus_wr_en && !busy && (bus_addr != A_COUNT) &&
                 (bus_addr != A_KEY || bus_wdata[15:0] == KEY);
  assign irq   = flag_b2;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_int_en <= 1'b0;
      sh_rst_en <= 1'b0;
      sh_ps     <= '0;
      sh_load   <= '0;
      req_tgl   <= 1'b0;
      ack_b1    <= 1'b0;
      ack_b2    <= 1'b0;
      cmd_kind  <= A_CTRL;
      cmd_data  <= '0;
      flag_b1   <= 1'b0;
      flag_b2   <= 1'b0;
      cnt_b1    <= '0;
      cnt_b2    <= '0;
      cnt_vis   <= '0;
    end else begin
      ack_b1  <= ack_tgl;
      ack_b2  <= ack_b1;
      flag_b1 <= flag;
      flag_b2 <= flag_b1;
      cnt_b1  <= cnt;
      cnt_b2  <= cnt_b1;
      if (cnt_b1 == cnt_b2) cnt_vis <= cnt_b2;
      if (wr_ok) begin
        req_tgl  <= ~req_tgl;
        cmd_kind <= bus_addr;
        cmd_data <= bus_wdata[CNT_W-1:0];
        if (bus_addr == A_CTRL) begin
          sh_int_en <= bus_wdata[0];
          sh_rst_en <= bus_wdata[1];
          sh_ps     <= bus_wdata[4 +: PS_W];
        end
        if (bus_addr == A_LOAD) sh_load <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]          = sh_int_en;
        bus_rdata[1]          = sh_rst_en;
        bus_rdata[2]          = flag_b2;
        bus_rdata[4 +: PS_W]  = sh_ps;
        bus_rdata[31]         = busy;
      end
      A_LOAD:  bus_rdata[CNT_W-1:0] = sh_load;
      A_COUNT: bus_rdata[CNT_W-1:0] = cnt_vis;
      default: bus_rdata = '0;
    endcase
  end

  assign div_mask = (DIV_W'(2) << ps) - DIV_W'(1);
  assign tick  = &(presc | ~div_mask);
  assign pend  = req_s2 ^ ack_tgl;
  assign apply = tick && pend;
  assign step  = tick && !pend && (run_int || run_rst);

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      presc        <= '0;
      req_s1       <= 1'b0;
      req_s2       <= 1'b0;
      ack_tgl      <= 1'b0;
      run_int      <= 1'b0;
      run_rst      <= 1'b0;
      ps           <= '0;
      load         <= '0;
      cnt          <= '0;
      flag         <= 1'b0;
      armed        <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      presc        <= presc + DIV_W'(1);
      req_s1       <= req_tgl;
      req_s2       <= req_s1;
      soft_rst_req <= 1'b0;
      if (apply) begin
        ack_tgl <= ~ack_tgl;
        case (cmd_kind)
          A_CTRL: begin
            run_int <= cmd_data[0];
            run_rst <= cmd_data[1];
            ps      <= cmd_data[4 +: PS_W];
            if (cmd_data[2]) flag <= 1'b0;
          end
          A_LOAD: load <= cmd_data;
          A_KEY: begin
            cnt   <= load;
            armed <= 1'b0;
          end
          default: ;
        endcase
      end else if (step) begin
        cnt <= (cnt == '0) ? load : cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          if (run_int && !(run_rst && armed)) flag <= 1'b1;
          if (run_int && run_rst && !armed) armed <= 1'b1;
          if (run_rst && (!run_int || armed)) soft_rst_req <= 1'b1;
        end
      end
    end
  end

  p_rst_pulse_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
    soft_rst_req |=> !soft_rst_req);
  p_rst_needs_en_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
    soft_rst_req |-> run_rst);
  p_second_expiry_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
    (soft_rst_req && run_int) |-> armed);
  p_flag_sticky_r5: assert property (@(posedge src_clk) disable iff (!rst_n)
    (flag && !apply) |=> flag);
  p_hold_r8: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!run_int && !run_rst && !apply) |=> $stable(cnt));
  p_key_ignored_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == A_KEY && bus_wdata[15:0] != KEY && !busy) |=> !busy);
  p_busy_stable_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_data));
endmodule

// File: tb/wdt_dual_timer_tb_top.sv
module wdt_dual_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EV_IRQ = 1, EV_RST = 2;

  logic bus_clk = 0, clk_a = 0, clk_b = 0, rst_n = 0, clk_sel = 0;
  logic bus_wr_en = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, soft_rst_req, src_mon, irq_q = 0;
  int vectors = 0, errors = 0, rst_cnt = 0, done = 0;
  longint stamp = 0, last = 0, last2 = 0;
  int q[$];

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #13 clk_a = ~clk_a;
  always #17 clk_b = ~clk_b;
  assign src_mon = clk_sel ? clk_b : clk_a;

  wdt_dual_timer dut_i (.bus_clk(bus_clk), .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b),
    .clk_sel(clk_sel), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .soft_rst_req(soft_rst_req));

  task automatic check(string tag, longint got, longint exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic got_event(int code);
    if (q.size() == 0) check("R6/R7 unexpected event", code, 0);
    else check("R5/R6/R7 event order", code, q.pop_front());
  endtask

  always @(posedge src_mon) stamp++;
  always @(negedge src_mon) if (rst_n && soft_rst_req) begin
    rst_cnt++; last2 = last; last = stamp; got_event(EV_RST);
  end
  always @(negedge bus_clk) if (rst_n) begin
    if (irq && !irq_q) got_event(EV_IRQ);
    irq_q = irq;
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge bus_clk); bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk); bus_wr_en = 0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge bus_clk); bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic idle();
    logic [31:0] d;
    do rd(0, d); while (d[31]);
    repeat (8) @(negedge bus_clk);
  endtask
  task automatic wait_src(int n);
    repeat (n) @(posedge src_mon);
  endtask

  task automatic measure_rst(logic sel, int ps, int rl);
    int n0;
    clk_sel = sel;
    wr(1, rl); idle();
    wr(3, 32'hA5C3); idle();
    q.push_back(EV_RST); q.push_back(EV_RST);
    n0 = rst_cnt;
    wr(0, 2 | (ps << 4));
    wait (rst_cnt == n0 + 2);
    wr(0, ps << 4); idle();
    check("R6/R2 pulse spacing", last - last2, longint'(rl + 1) << (ps + 1));
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog timeout", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d, d2;
    int n0;
    repeat (3) @(negedge bus_clk);
    rst_n = 1;
    repeat (3) @(negedge bus_clk);
    rd(0, d); check("R1 control", d, 0);
    rd(1, d); check("R1 reload", d, 0);
    rd(2, d); check("R1 count", d, 0);
    check("R1 irq", irq, 0);
    check("R1 soft reset", soft_rst_req, 0);

    wr(1, 5);
    rd(0, d); check("R3 busy after write", d[31], 1);
    idle();
    wr(1, 7);
    wr(1, 9);
    idle();
    rd(1, d); check("R3 write while busy dropped", d, 7);
    wr(1, 5); idle();

    wr(3, 32'h1234);
    rd(0, d); check("R4 bad key no busy", d[31], 0);
    wait_src(20);
    rd(2, d); check("R4 bad key count unchanged", d, 0);
    wr(3, 32'hA5C3); idle();
    rd(2, d); check("R4 restart loads count", d, 5);
    wait_src(40);
    rd(2, d); check("R8 count holds when disabled", d, 5);

    q.push_back(EV_IRQ);
    wr(0, 1);
    wait (irq);
    rd(0, d); check("R5 flag set", d[2], 1);
    wr(0, 4); idle();
    check("R5 irq cleared", irq, 0);
    rd(0, d); check("R5 flag cleared", d[2], 0);
    rd(2, d); wait_src(40); rd(2, d2);
    check("R8 count frozen after disable", d2, d);

    measure_rst(1, 1, 5);
    measure_rst(0, 3, 2);
    clk_sel = 0;

    wr(1, 5); idle();
    wr(3, 32'hA5C3); idle();
    q.push_back(EV_IRQ); q.push_back(EV_RST);
    n0 = rst_cnt;
    wr(0, 3);
    wait (rst_cnt == n0 + 1);
    wr(0, 4); idle();
    check("R7 warning then reset", q.size(), 0);

    wr(1, 20); idle();
    wr(3, 32'hA5C3); idle();
    q.push_back(EV_IRQ);
    wr(0, 3);
    wait (irq);
    wr(3, 32'hA5C3); idle();
    n0 = rst_cnt;
    wait_src(60);
    check("R7 restart defers reset", rst_cnt, n0);
    q.push_back(EV_RST);
    wait (rst_cnt == n0 + 1);
    wr(0, 4); idle();
    check("R7 deferred reset seen", q.size(), 0);
    finish_run();
  end
endmodule